// File: doc/BRIEF.md
# Periodic Real-Time-Clock Interrupt Engine

This block is the periodic-interrupt part of a real-time clock. Software picks an interrupt rate through a 4-bit rate code and a 3-bit time-base field in a control register. The block turns that choice into a count of core clock cycles and counts it down. Each time the count runs out, it raises a periodic flag in a status register and drives an interrupt line.

An enable bit in a second control register gates the whole mechanism. The status register also holds an update flag and an alarm flag. Other logic raises those two flags through single-cycle event inputs. The top bit of the status register is the OR of all three flags. Reading the status register clears it and drops the interrupt.

Access goes through a byte-wide register port with separate read and write strobes. The read data path is combinational from the addressed register. The core clock frequency is a parameter. Every period comes from it by a constant shift, because all rates are powers of two.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, registers at indices 0x0A, 0x0B and 0x0C read 0x00 and `irq` is low.
- R2: For rate codes 3 to 15 the rate is 2^(16-code) Hz. The first periodic flag appears exactly CLK_HZ/rate cycles after the countdown is reloaded.
- R3: Rate codes 1 and 2 depend on the time-base field in bits 6:4 of register 0x0A. When that field is 3'b010 (slow base), the rates are 256 Hz and 128 Hz. Any other value gives 32768 Hz and 16384 Hz.
- R4: Rate code 0 produces no periodic flag and no interrupt, whatever the enable bit.
- R5: A write to index 0x0A stores only bits 6:0 (bit 7 reads 0) and reloads the countdown with the new full period.
- R6: The countdown runs only while bit 6 of index 0x0B is 1. A write that changes that bit reloads the countdown.
- R7: A write to index 0x0B with bit 6 clear deasserts `irq`. The periodic flag is left set.
- R8: On expiry, bit 6 of index 0x0C is set and `irq` is asserted. Counting continues with the same spacing, so no cycles drift.
- R9: `upd_evt` sets bit 4 and `alm_evt` sets bit 5 of index 0x0C. Bit 7 reads as the OR of bits 6, 5 and 4.
- R10: A read of index 0x0C returns the current value. It then clears every flag and deasserts `irq`.
- R11: A flag event that lands in the same cycle as a read of index 0x0C wins and stays pending.
- R12: Writes to index 0x0C or to unused indices change nothing. Reads of unused indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | AW | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| upd_evt | input | 1 | Update-ended event pulse |
| alm_evt | input | 1 | Alarm-match event pulse |
| irq | output | 1 | Periodic interrupt output |

## Verification
A table of time-base and rate-code pairs is applied. Each pair's period is measured in cycles from the reload to the first flag. This separates the fixed-rate codes from the two codes that depend on the time base, and the slow base from the fast ones. Directed cases cover the remaining behaviour:
- spacing between consecutive flags, which exposes drift;
- the disable and reload paths;
- a status read that coincides with an expiry or an event;
- writes that must not stick.

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int CLK_HZ = 1048576,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          upd_evt,
  input  logic          alm_evt,
  output logic          irq
);
  localparam int CW = $clog2(CLK_HZ + 1);
  localparam logic [31:0] HZ = 32'(CLK_HZ);
  localparam logic [AW-1:0] IDX_CTLA = AW'(10);
  localparam logic [AW-1:0] IDX_CTLB = AW'(11);
  localparam logic [AW-1:0] IDX_STAT = AW'(12);
  localparam logic [2:0] SLOW_BASE = 3'b010;

  function automatic logic [CW-1:0] calc_period(input logic [6:0] a);
    logic [4:0] sh;
    logic slow;
    slow = (a[6:4] == SLOW_BASE);
    case (a[3:0])
      4'd0:    sh = 5'd0;
      4'd1:    sh = slow ? 5'd8 : 5'd15;
      4'd2:    sh = slow ? 5'd7 : 5'd14;
      default: sh = 5'd16 - {1'b0, a[3:0]};
    endcase
    return (a[3:0] == 4'd0) ? '0 : CW'(HZ >> sh);
  endfunction

  logic [6:0]    ctl_a;
  logic [7:0]    ctl_b;
  logic          pf, af, uf;
  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic          run, tick, wr_a, wr_b, rd_c, pie_off;

  assign period  = calc_period(ctl_a);
  assign run     = ctl_b[6] && (period != '0);
  assign tick    = run && (cnt == CW'(1));
  assign wr_a    = wr_en && (addr == IDX_CTLA);
  assign wr_b    = wr_en && (addr == IDX_CTLB);
  assign rd_c    = rd_en && (addr == IDX_STAT);
  assign pie_off = wr_b && !wdata[6];

  always_comb begin
    case (addr)
      IDX_CTLA: rdata = {1'b0, ctl_a};
      IDX_CTLB: rdata = ctl_b;
      IDX_STAT: rdata = {pf | af | uf, pf, af, uf, 4'b0000};
      default:  rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a <= '0;
      ctl_b <= '0;
      cnt   <= '0;
    end else begin
      if (wr_a) ctl_a <= wdata[6:0];
      if (wr_b) ctl_b <= wdata;
      if (wr_a)                               cnt <= calc_period(wdata[6:0]);
      else if (wr_b && (wdata[6] ^ ctl_b[6])) cnt <= period;
      else if (tick)                          cnt <= period;
      else if (run)                           cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf  <= 1'b0;
      af  <= 1'b0;
      uf  <= 1'b0;
      irq <= 1'b0;
    end else begin
      pf <= tick    ? 1'b1 : (rd_c ? 1'b0 : pf);
      af <= alm_evt ? 1'b1 : (rd_c ? 1'b0 : af);
      uf <= upd_evt ? 1'b1 : (rd_c ? 1'b0 : uf);
      if (pie_off)   irq <= 1'b0;
      else if (tick) irq <= 1'b1;
      else if (rd_c) irq <= 1'b0;
    end
  end

  // R8: the interrupt line is never high without a pending periodic flag
  a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pf);
  // R6: a new periodic flag needs the engine to have been running
  a_r6_flag_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf) |-> $past(run));
  // R10: a status read with no competing event leaves every flag clear
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !tick && !upd_evt && !alm_evt) |=> (!pf && !af && !uf && !irq));
  // R7: disabling the engine drops the interrupt
  a_r7_disable_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pie_off |=> !irq);
  // R2: the countdown never exceeds the current period
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period);
  // R11: an update event in the same cycle as a status read survives it
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && upd_evt) |=> uf);
endmodule

// File: tb/rtc_periodic_irq_tb.sv
module rtc_periodic_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 65536;
  localparam int NV = 9;
  // {time base[2:0], rate code[3:0], expected period[16:0]}
  localparam logic [23:0] VEC [NV] = '{
    {3'b010, 4'd3,  17'd8},
    {3'b010, 4'd6,  17'd64},
    {3'b010, 4'd1,  17'd256},
    {3'b001, 4'd1,  17'd2},
    {3'b000, 4'd2,  17'd4},
    {3'b010, 4'd2,  17'd512},
    {3'b010, 4'd10, 17'd1024},
    {3'b001, 4'd13, 17'd8192},
    {3'b000, 4'd15, 17'd32768}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic upd_evt = 1'b0, alm_evt = 1'b0, irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_periodic_irq #(.CLK_HZ(HZ), .AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .upd_evt(upd_evt), .alm_evt(alm_evt), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdc(output logic [7:0] v);
    addr = 4'hC; rd_en = 1'b1; #1; v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_pf(input int limit, output int n);
    logic [7:0] v;
    n = 0;
    peek(4'hC, v);
    while (!v[6] && n < limit) begin
      @(negedge clk); n++; peek(4'hC, v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(4'hA, v); check("R1 ctl A reset", v, 8'h00);
    peek(4'hB, v); check("R1 ctl B reset", v, 8'h00);
    peek(4'hC, v); check("R1 status reset", v, 8'h00);
    check("R1 irq reset", irq, 0);

    // R2 / R3: table of rates
    for (int i = 0; i < NV; i++) begin
      wr(4'hB, 8'h00);
      rdc(v);
      wr(4'hA, {1'b0, VEC[i][23:17]});
      wr(4'hB, 8'h40);
      wait_pf(40000, n);
      check($sformatf("R2 R3 period vec%0d", i), n, int'(VEC[i][16:0]));
    end

    // R5: only bits 6:0 kept
    wr(4'hB, 8'h00);
    wr(4'hA, 8'hFF);
    peek(4'hA, v); check("R5 ctl A mask", v, 8'h7F);

    // R4: rate code 0
    rdc(v);
    wr(4'hA, 8'h20);
    wr(4'hB, 8'h40);
    repeat (300) @(negedge clk);
    peek(4'hC, v); check("R4 no flag code0", v, 8'h00);
    check("R4 no irq code0", irq, 0);

    // R5: A write mid-count reloads
    wr(4'hA, 8'h26);
    repeat (30) @(negedge clk);
    wr(4'hA, 8'h26);
    wait_pf(200, n); check("R5 reload on ctl A write", n, 64);

    // R8 / R10: flag, irq, spacing, read-clear
    wr(4'hB, 8'h00); rdc(v);
    wr(4'hA, 8'h23);
    wr(4'hB, 8'h40);
    wait_pf(100, n); check("R8 first flag", n, 8);
    check("R8 irq set", irq, 1);
    rdc(v); check("R10 read value", v, 8'hC0);
    peek(4'hC, v); check("R10 cleared", v, 8'h00);
    check("R10 irq cleared", irq, 0);
    wait_pf(100, n); check("R8 no drift spacing", n, 7);

    // R7: disable drops irq, keeps flag
    wr(4'hB, 8'h00);
    check("R7 irq off", irq, 0);
    peek(4'hC, v); check("R7 flag kept", v, 8'hC0);

    // R6: stopped while disabled; toggle reloads
    rdc(v);
    repeat (100) @(negedge clk);
    peek(4'hC, v); check("R6 stopped", v, 8'h00);
    wr(4'hA, 8'h26);
    wr(4'hB, 8'h40);
    repeat (40) @(negedge clk);
    wr(4'hB, 8'h00);
    wr(4'hB, 8'h40);
    wait_pf(200, n); check("R6 toggle reload", n, 64);

    // R9: summary bit and event flags
    wr(4'hB, 8'h00); rdc(v);
    upd_evt = 1'b1; @(negedge clk); upd_evt = 1'b0;
    peek(4'hC, v); check("R9 update flag", v, 8'h90);
    rdc(v);
    alm_evt = 1'b1; @(negedge clk); alm_evt = 1'b0;
    peek(4'hC, v); check("R9 alarm flag", v, 8'hA0);
    rdc(v);

    // R11: event coincides with read
    addr = 4'hC; rd_en = 1'b1; upd_evt = 1'b1;
    @(negedge clk); rd_en = 1'b0; upd_evt = 1'b0;
    peek(4'hC, v); check("R11 update survives read", v, 8'h90);
    rdc(v);
    wr(4'hA, 8'h23);
    wr(4'hB, 8'h40);
    repeat (7) @(negedge clk);
    addr = 4'hC; rd_en = 1'b1; #1;
    check("R11 read before expiry", rdata, 8'h00);
    @(negedge clk); rd_en = 1'b0;
    peek(4'hC, v); check("R11 expiry survives read", v, 8'hC0);
    check("R11 irq survives read", irq, 1);

    // R12: ignored writes
    wr(4'hB, 8'h00); rdc(v);
    wr(4'hC, 8'hFF);
    peek(4'hC, v); check("R12 status write ignored", v, 8'h00);
    wr(4'h3, 8'h5A);
    peek(4'h3, v); check("R12 unused index", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule